// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small eight-bit processor core. Each cycle it takes two operands and a five-bit operation code. It produces the result and a write-back enable without any register stage. It also holds the eight-bit status byte in a register. When an operation is issued, the register is updated at the next rising clock edge. The status value held in the register is the incoming status for the next operation, so the carry and zero flags can chain across operations.

The operations are:
- add and subtract, each with or without carry
- compare, with or without carry
- bitwise AND, OR and XOR
- one's and two's complement
- increment and decrement
- logical shifts, rotates through carry and an arithmetic right shift
- nibble swap

Every operation writes a fixed subset of the flags. All other flags keep their previous values. The status byte, from bit 7 down to bit 0, is: interrupt-enable (I), transfer bit (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z), carry (C). The sign flag always equals N XOR V.

Top module: `alu8_status`

## Requirements
- R1: After reset the status output is 0x00. When `valid_i` is low at a rising edge, the status byte is unchanged.
- R2: Add (code 0) and add-with-carry (code 1) return a+b, or a+b+C. They set C to the carry out of bit 7, H to the carry out of bit 3, V to the signed overflow, N to result bit 7 and Z when the result is zero.
- R3: Subtract (code 2) and subtract-with-carry (code 3) return a−b, or a−b−C. They set C to the borrow out of bit 7, H to the borrow into bit 4, V to the signed overflow, and N and Z from the result.
- R4: For subtract-with-carry (code 3) and compare-with-carry (code 5), Z is set only when the result is zero and Z was already set before the operation. In every other case Z is cleared.
- R5: Compare (code 4) and compare-with-carry (code 5) update H, V, N, Z and C exactly as the subtract pair does, but drive `wr_en_o` low.
- R6: AND (code 6), OR (code 7) and XOR (code 8) update only Z and N, clear V, and leave C and H unchanged.
- R7: One's complement (code 9) returns 0xFF−a and sets C=1 and V=0. Two's complement (code 10) returns 0x00−a and sets C when the result is non-zero, V when the result is 0x80, and H as the borrow into bit 4.
- R8: Increment (code 11) and decrement (code 12) update only Z, N and V. V is set when the operand is 0x7F for increment, or 0x80 for decrement. C and H are unchanged.
- R9: Shift-left (code 13) moves a zero into bit 0. Shift-right (code 14) moves a zero into bit 7. In both, the bit shifted out goes to C, V becomes N XOR C, and H is unchanged.
- R10: Rotate-left (code 15) and rotate-right (code 16) move the old C into the vacated end and the shifted-out bit into C, with V = N XOR C.
- R11: Arithmetic shift right (code 17) keeps bit 7, moves bit 0 into C and sets V = N XOR C.
- R12: Nibble swap (code 18) exchanges bits 7..4 with bits 3..0 and changes no flag.
- R13: In the stored status byte, S (bit 4) always equals N (bit 2) XOR V (bit 3). I (bit 7) and T (bit 6) are never written by any operation, so they stay 0 after reset.
- R14: `wr_en_o` is high for every issued operation with codes 0–3 and 6–18. It is low when `valid_i` is low. Codes 19–31 drive `wr_en_o` low and leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand |
| res_o | output | 8 | Result, combinational |
| wr_en_o | output | 1 | Result is to be written back, combinational |
| sreg_o | output | 8 | Registered status byte |

## Verification
`res_o` and `wr_en_o` are due in the same cycle the operands are applied, because no register lies on their path. The bench drives inputs on the falling edge and samples these two outputs a few nanoseconds later. The status byte passes through one register, so its new value appears only after the next rising edge. The bench therefore compares `sreg_o` with its model at the following falling edge, before it drives the next operation.

Operation sequences are run back to back so that carry and zero chain through the register. This exercises the with-carry and sticky-zero paths with both values of the incoming flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W  = 8;
    localparam int FLAG_W = 8;
    localparam int OP_W   = 5;

    // status bit positions (layout is part of the block's behaviour)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_EOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    // one unit's contribution: zero everywhere when the op is not its own
    typedef struct packed {
        logic [ALU_W-1:0]  res;
        logic [FLAG_W-1:0] flg;
        logic [FLAG_W-1:0] msk;
        logic              wb;
    } alu_part_t;

    typedef struct packed {
        logic [FLAG_W-1:0] sreg;
    } alu_state_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [ALU_W-1:0]  a,
    input  logic [ALU_W-1:0]  b,
    input  logic [FLAG_W-1:0] sreg,
    output alu_part_t         part
);

    localparam int MSB = ALU_W - 1;
    localparam int HB  = ALU_W / 2 - 1;

    logic [ALU_W-1:0] x, y, r;
    logic             cin, sub, mine, inc_dec, z_sticky;
    logic             hc, vc, cc;

    always_comb begin
        x        = a;
        y        = b;
        cin      = 1'b0;
        sub      = 1'b0;
        mine     = 1'b1;
        inc_dec  = 1'b0;
        z_sticky = 1'b0;
        case (op)
            OP_ADD: ;
            OP_ADC: cin = sreg[F_C];
            OP_SUB, OP_CP: sub = 1'b1;
            OP_SBC, OP_CPC: begin
                sub      = 1'b1;
                cin      = sreg[F_C];
                z_sticky = 1'b1;
            end
            OP_NEG: begin
                sub = 1'b1;
                x   = '0;
                y   = a;
            end
            OP_INC: begin
                y       = ALU_W'(1);
                inc_dec = 1'b1;
            end
            OP_DEC: begin
                sub     = 1'b1;
                y       = ALU_W'(1);
                inc_dec = 1'b1;
            end
            default: mine = 1'b0;
        endcase

        r = sub ? (x - y - ALU_W'(cin)) : (x + y + ALU_W'(cin));

        if (sub) begin
            hc = (~x[HB] & y[HB]) | (y[HB] & r[HB]) | (r[HB] & ~x[HB]);
            cc = (~x[MSB] & y[MSB]) | (y[MSB] & r[MSB]) | (r[MSB] & ~x[MSB]);
            vc = (x[MSB] & ~y[MSB] & ~r[MSB]) | (~x[MSB] & y[MSB] & r[MSB]);
        end else begin
            hc = (x[HB] & y[HB]) | (y[HB] & ~r[HB]) | (~r[HB] & x[HB]);
            cc = (x[MSB] & y[MSB]) | (y[MSB] & ~r[MSB]) | (~r[MSB] & x[MSB]);
            vc = (x[MSB] & y[MSB] & ~r[MSB]) | (~x[MSB] & ~y[MSB] & r[MSB]);
        end

        part = '0;
        if (mine) begin
            part.res      = r;
            part.wb       = !(op == OP_CP || op == OP_CPC);
            part.flg[F_H] = hc;
            part.flg[F_C] = cc;
            part.flg[F_V] = vc;
            part.flg[F_N] = r[MSB];
            part.flg[F_Z] = (r == '0) && (!z_sticky || sreg[F_Z]);
            part.msk[F_Z] = 1'b1;
            part.msk[F_N] = 1'b1;
            part.msk[F_V] = 1'b1;
            part.msk[F_H] = !inc_dec;
            part.msk[F_C] = !inc_dec;
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [ALU_W-1:0]  a,
    input  logic [ALU_W-1:0]  b,
    output alu_part_t         part
);

    localparam int MSB  = ALU_W - 1;
    localparam int HALF = ALU_W / 2;

    logic [ALU_W-1:0] r;
    logic             mine, sets_c, flagless;

    always_comb begin
        mine     = 1'b1;
        sets_c   = 1'b0;
        flagless = 1'b0;
        r        = '0;
        case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_EOR: r = a ^ b;
            OP_COM: begin
                r      = ~a;
                sets_c = 1'b1;
            end
            OP_SWAP: begin
                r        = {a[HALF-1:0], a[MSB:HALF]};
                flagless = 1'b1;
            end
            default: mine = 1'b0;
        endcase

        part = '0;
        if (mine) begin
            part.res = r;
            part.wb  = 1'b1;
            if (!flagless) begin
                part.flg[F_N] = r[MSB];
                part.flg[F_Z] = (r == '0);
                part.flg[F_V] = 1'b0;
                part.flg[F_C] = 1'b1;
                part.msk[F_N] = 1'b1;
                part.msk[F_Z] = 1'b1;
                part.msk[F_V] = 1'b1;
                part.msk[F_C] = sets_c;
            end
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [ALU_W-1:0]  a,
    input  logic [FLAG_W-1:0] sreg,
    output alu_part_t         part
);

    localparam int MSB = ALU_W - 1;

    logic [ALU_W-1:0] r;
    logic             out_bit, mine;

    always_comb begin
        mine    = 1'b1;
        r       = '0;
        out_bit = 1'b0;
        case (op)
            OP_LSL: begin r = {a[MSB-1:0], 1'b0};        out_bit = a[MSB]; end
            OP_LSR: begin r = {1'b0, a[MSB:1]};          out_bit = a[0];   end
            OP_ROL: begin r = {a[MSB-1:0], sreg[F_C]};   out_bit = a[MSB]; end
            OP_ROR: begin r = {sreg[F_C], a[MSB:1]};     out_bit = a[0];   end
            OP_ASR: begin r = {a[MSB], a[MSB:1]};        out_bit = a[0];   end
            default: mine = 1'b0;
        endcase

        part = '0;
        if (mine) begin
            part.res      = r;
            part.wb       = 1'b1;
            part.flg[F_C] = out_bit;
            part.flg[F_N] = r[MSB];
            part.flg[F_Z] = (r == '0);
            part.flg[F_V] = r[MSB] ^ out_bit;
            part.msk[F_C] = 1'b1;
            part.msk[F_N] = 1'b1;
            part.msk[F_Z] = 1'b1;
            part.msk[F_V] = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [ALU_W-1:0]  a_i,
    input  logic [ALU_W-1:0]  b_i,
    output logic [ALU_W-1:0]  res_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] sreg_o
);

    alu_state_t st_d, st_q;
    alu_part_t  p_arith, p_bit, p_shift, p_all;
    logic [FLAG_W-1:0] merged;

    alu8_addsub u_addsub (
        .op   (op_i),
        .a    (a_i),
        .b    (b_i),
        .sreg (st_q.sreg),
        .part (p_arith)
    );

    alu8_bitwise u_bitwise (
        .op   (op_i),
        .a    (a_i),
        .b    (b_i),
        .part (p_bit)
    );

    alu8_shift u_shift (
        .op   (op_i),
        .a    (a_i),
        .sreg (st_q.sreg),
        .part (p_shift)
    );

    always_comb begin
        // units are exclusive: all but one contribute zero
        p_all  = p_arith | p_bit | p_shift;
        merged = (st_q.sreg & ~p_all.msk) | (p_all.flg & p_all.msk);
        if (p_all.msk[F_N] || p_all.msk[F_V]) begin
            merged[F_S] = merged[F_N] ^ merged[F_V];
        end

        st_d = st_q;
        if (valid_i) begin
            st_d.sreg = merged;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = p_all.res;
    assign wr_en_o = valid_i & p_all.wb;
    assign sreg_o  = st_q.sreg;

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
    import alu8_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] sreg_o
);

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> sreg_o == $past(sreg_o)); // R1

    AST_CMP_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (op_i == OP_CP || op_i == OP_CPC)) |-> !wr_en_o); // R5

    AST_LOGIC_CLEARS_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_EOR))
        |=> !sreg_o[F_V]); // R6

    AST_INCDEC_KEEP_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (op_i == OP_INC || op_i == OP_DEC))
        |=> (sreg_o[F_C] == $past(sreg_o[F_C]) && sreg_o[F_H] == $past(sreg_o[F_H]))); // R8

    AST_SWAP_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_SWAP) |=> sreg_o == $past(sreg_o)); // R12

    AST_SIGN_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sreg_o[F_S] == (sreg_o[F_N] ^ sreg_o[F_V])); // R13

    AST_IT_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sreg_o[F_I] == 1'b0 && sreg_o[F_T] == 1'b0); // R13

    AST_IDLE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> !wr_en_o); // R14

    AST_UNUSED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i > OP_SWAP) |=> sreg_o == $past(sreg_o)); // R14

endmodule

bind alu8_status alu8_status_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .wr_en_o (wr_en_o),
    .sreg_o  (sreg_o)
);

// File: tb/sim_alu8_status.sv
module sim_alu8_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic [7:0] res;
    logic       wr_en;
    logic [7:0] sreg;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_sreg = 0;
    string last_tag = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_status u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .valid_i (valid),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .res_o   (res),
        .wr_en_o (wr_en),
        .sreg_o  (sreg)
    );

    function automatic int sx(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string req_of(int code);
        case (code)
            0, 1:          return "R2";
            2:             return "R3";
            3:             return "R3 R4";
            4:             return "R5";
            5:             return "R5 R4";
            6, 7, 8:       return "R6";
            9, 10:         return "R7";
            11, 12:        return "R8";
            13, 14:        return "R9";
            15, 16:        return "R10";
            17:            return "R11";
            18:            return "R12";
            default:       return "R14";
        endcase
    endfunction

    // behavioural model from the requirement list
    function automatic void model(input int code, input int x, input int y, input int s,
                                  output int r, output int wb, output int ns);
        int c, z, t, cin, sv;
        int fc, fz, fn, fv, fh;
        bit wc, wz, wn, wv, wh;
        c = s & 1; z = (s >> 1) & 1;
        r = 0; wb = 1; ns = s;
        fc = 0; fz = 0; fn = 0; fv = 0; fh = 0;
        wc = 0; wz = 0; wn = 0; wv = 0; wh = 0;
        case (code)
            0, 1: begin
                cin = (code == 1) ? c : 0;
                t = x + y + cin; r = t & 255;
                fc = (t > 255); fh = ((x & 15) + (y & 15) + cin) > 15;
                sv = sx(x) + sx(y) + cin; fv = (sv > 127 || sv < -128);
                wc = 1; wh = 1; wv = 1; wn = 1; wz = 1; fz = (r == 0);
            end
            2, 3, 4, 5, 10: begin
                int m, d;
                m = (code == 10) ? 0 : x;
                d = (code == 10) ? x : y;
                cin = (code == 3 || code == 5) ? c : 0;
                t = m - d - cin; r = t & 255;
                fc = (t < 0); fh = ((m & 15) - (d & 15) - cin) < 0;
                sv = sx(m) - sx(d) - cin; fv = (sv > 127 || sv < -128);
                fz = (r == 0);
                if (code == 3 || code == 5) fz = fz && (z == 1);
                wc = 1; wh = 1; wv = 1; wn = 1; wz = 1;
                if (code == 4 || code == 5) wb = 0;
            end
            6, 7, 8: begin
                r = (code == 6) ? (x & y) : (code == 7) ? (x | y) : (x ^ y);
                wz = 1; wn = 1; wv = 1; fz = (r == 0); fv = 0;
            end
            9: begin
                r = 255 - x; wz = 1; wn = 1; wv = 1; wc = 1;
                fz = (r == 0); fv = 0; fc = 1;
            end
            11, 12: begin
                r = (code == 11) ? ((x + 1) & 255) : ((x + 255) & 255);
                fv = (code == 11) ? (x == 127) : (x == 128);
                wz = 1; wn = 1; wv = 1; fz = (r == 0);
            end
            13, 14, 15, 16, 17: begin
                case (code)
                    13: begin r = (x * 2) & 255;       fc = x >> 7; end
                    14: begin r = x / 2;               fc = x & 1;  end
                    15: begin r = (x * 2 + c) & 255;   fc = x >> 7; end
                    16: begin r = x / 2 + c * 128;     fc = x & 1;  end
                    default: begin r = x / 2 + (x & 128); fc = x & 1; end
                endcase
                fn = (r >> 7) & 1; fv = fn ^ fc; fz = (r == 0);
                wc = 1; wn = 1; wv = 1; wz = 1;
            end
            18: r = ((x & 15) << 4) | (x >> 4);
            default: wb = 0;
        endcase
        fn = (r >> 7) & 1;
        if (wc) ns = (ns & ~1)  | fc;
        if (wz) ns = (ns & ~2)  | (fz << 1);
        if (wn) ns = (ns & ~4)  | (fn << 2);
        if (wv) ns = (ns & ~8)  | (fv << 3);
        if (wh) ns = (ns & ~32) | (fh << 5);
        if (wn || wv) ns = (ns & ~16) | ((((ns >> 2) ^ (ns >> 3)) & 1) << 4);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // status comparison for the op issued on the previous cycle
    task automatic check_sreg();
        check(sreg == 8'(exp_sreg), last_tag, sreg, exp_sreg);
        check(sreg[4] == (sreg[2] ^ sreg[3]) && sreg[7:6] == 2'b00, "R13", sreg, exp_sreg);
    endtask

    task automatic step(input bit v, input int code, input int x, input int y);
        int r, wb, ns;
        @(negedge clk);
        check_sreg();
        valid = v; op = 5'(code); a = 8'(x); b = 8'(y);
        if (v) begin
            model(code, x, y, exp_sreg, r, wb, ns);
        end else begin
            r = 0; wb = 0; ns = exp_sreg;
        end
        #5;
        if (wb != 0) check(res == 8'(r), req_of(code), res, r);
        check(wr_en == (wb != 0), v ? "R14 R5" : "R1 R14", wr_en, wb);
        exp_sreg = ns;
        last_tag = v ? req_of(code) : "R1";
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sreg == 8'h00, "R1 reset", sreg, 0);
        rst_n = 1'b1;
        exp_sreg = 0;

        // directed corners
        step(1, 0, 8'hFF, 8'h01);   // R2: carry, zero, half carry
        step(1, 1, 8'h10, 8'h20);   // R2: ADC with C=1
        step(1, 0, 8'h7F, 8'h01);   // R2: signed overflow
        step(1, 2, 8'h00, 8'h01);   // R3: borrow
        step(1, 3, 8'h10, 8'h0F);   // R3: SBC with C=1 -> zero, Z clear on entry
        step(1, 4, 8'h55, 8'h55);   // R5: CP equal -> Z set
        step(1, 5, 8'h55, 8'h55);   // R4: CPC zero with Z set -> stays
        step(1, 5, 8'h56, 8'h55);   // R4: non-zero clears Z
        step(1, 5, 8'h55, 8'h55);   // R4: zero but Z clear -> stays clear
        step(0, 0, 8'h01, 8'h01);   // R1: idle holds
        step(1, 10, 8'h80, 8'h00);  // R7: NEG 0x80
        step(1, 10, 8'h00, 8'h00);  // R7: NEG 0
        step(1, 9, 8'h00, 8'h00);   // R7: COM
        step(1, 11, 8'h7F, 8'h00);  // R8: INC overflow keeps C
        step(1, 12, 8'h80, 8'h00);  // R8: DEC overflow
        step(1, 12, 8'h01, 8'h00);  // R8: DEC to zero
        step(1, 13, 8'h81, 8'h00);  // R9
        step(1, 14, 8'h01, 8'h00);  // R9
        step(1, 15, 8'h80, 8'h00);  // R10: rotate, C in
        step(1, 16, 8'h01, 8'h00);  // R10
        step(1, 17, 8'h81, 8'h00);  // R11
        step(1, 18, 8'hA5, 8'h00);  // R12
        step(1, 25, 8'hFF, 8'hFF);  // R14: unused code
        step(1, 6, 8'hF0, 8'h0F);   // R6
        step(1, 7, 8'h80, 8'h00);   // R6
        step(1, 8, 8'hAA, 8'hAA);   // R6

        // chained pseudo-random traffic over every code
        for (int i = 0; i < 1500; i++) begin
            int code;
            code = $urandom_range(0, 21);
            step(($urandom_range(0, 7) != 0), code,
                 $urandom_range(0, 255), $urandom_range(0, 255));
        end

        @(negedge clk);
        check_sreg();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule